// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow Traps

This unit forms the integer result for one arithmetic operation of a 64-bit datapath. Each accepted operation takes a first source, a second source and a 4-bit operation code. The second source is either a register value or an 8-bit immediate that is zero-extended. A width select picks 32-bit longword or 64-bit quadword arithmetic. The operation set covers clear, absolute value, negate, longword sign extension, add and subtract, and add and subtract with the first source scaled by 4 or 8.

Add, subtract and negate each exist in a form that traps and a form that does not. Absolute value always traps on overflow, and the scaled forms never trap. In longword mode only the low 32 bits of each source take part. Every longword result is sign-extended from bit 31 to fill all 64 bits.

The result and the overflow flag are registered. Both appear one cycle after the operation is presented. The flag marks that cycle only. Decode, register file access and delivery of the exception are left to the surrounding pipeline.

Top module: `int_arith_unit`

## Requirements
- R1: While `rst_n` is low, and on the first sampled cycle after reset is released, `out_valid`, `ovf_trap` and `result` are all 0.
- R2: An operation presented with `in_valid`=1 at a rising edge is reflected on `result`, `out_valid` and `ovf_trap` right after that edge, which is one cycle of latency. `out_valid` is high for exactly one cycle per accepted operation. `result` holds its value while `in_valid` is 0, and `ovf_trap` stays 0 during that time.
- R3: Code 0 (clear) gives `result`=0 with no trap. The codes 13 to 15 are not assigned, and they behave exactly as clear.
- R4: Code 5 (add) and code 6 (add, trapping) give a+b. Code 7 (subtract) and code 8 (subtract, trapping) give a-b. b is `src_b` when `use_imm`=0. When `use_imm`=1, b is `src_imm` zero-extended and `src_b` is ignored.
- R5: Code 9 gives 4a+b and code 10 gives 8a+b. Code 11 gives 4a-b and code 12 gives 8a-b. All four wrap at the selected width and never raise `ovf_trap`.
- R6: When `quad_sel`=0 (longword), only bits 31:0 of each source are used. `result`[63:32] then equals `result`[31] for every code. When `quad_sel`=1, all 64 bits are used.
- R7: Code 2 (negate) and code 3 (negate, trapping) give 0-a. For the most negative value of the width, both codes return that same value. Code 3 flags a trap on that value and code 2 does not.
- R8: Code 1 (absolute value) gives |a|. When a is the most negative value of the width (-2^31 or -2^63), the result is that same value and `ovf_trap` is raised.
- R9: Code 4 (sign-extend longword) gives bits 31:0 of a with bit 31 copied into bits 63:32, whatever `quad_sel` is set to.
- R10: Codes 6 and 8 raise `ovf_trap` when the exact sum or difference cannot be held as a signed value of the selected width. The result is then the wrapped value. Codes 5 and 7 return the same value with no trap.
- R11: `ovf_trap` is high only in a cycle where `out_valid` is high, and only for codes 1, 3, 6 and 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 4 | Operation code (see requirements) |
| quad_sel | input | 1 | 1 = 64-bit, 0 = 32-bit arithmetic |
| src_a | input | 64 | First source |
| src_b | input | 64 | Second source, register form |
| src_imm | input | 8 | Second source, immediate form |
| use_imm | input | 1 | Select zero-extended immediate as second source |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 64 | Destination value |
| ovf_trap | output | 1 | Overflow trap for the result in this cycle |

## Verification
Add and subtract are driven first with small operands, where nothing overflows. They are then driven with operands just past the positive and negative limits of each width, which separates a correct wrap from a correct trap. The trapping and non-trapping codes get identical operands, so any difference between them can only come from trap gating. Longword tests put unrelated data in bits 63:32 of the sources, which shows that those bits are truly ignored. The most negative value is sent through negate and absolute value at both widths. Scaled operands are chosen so the shifted value overflows, and this confirms that the scaled forms stay silent. Back-to-back operations with idle gaps between them check the one-cycle flag and the holding of the result.

// File: rtl/arith_unit_pkg.sv
package arith_unit_pkg;

  typedef enum logic [3:0] {
    OP_CLR   = 4'd0,
    OP_ABS   = 4'd1,
    OP_NEG   = 4'd2,
    OP_NEGV  = 4'd3,
    OP_SEXT  = 4'd4,
    OP_ADD   = 4'd5,
    OP_ADDV  = 4'd6,
    OP_SUB   = 4'd7,
    OP_SUBV  = 4'd8,
    OP_S4ADD = 4'd9,
    OP_S8ADD = 4'd10,
    OP_S4SUB = 4'd11,
    OP_S8SUB = 4'd12
  } arith_op_e;

  // Per-operation datapath controls
  typedef struct packed {
    logic       clear;     // force result to zero
    logic       sext;      // sign-extend low half of first source
    logic       x_zero;    // adder left input forced to zero
    logic       y_is_a;    // adder right input taken from first source
    logic       abs_mode;  // conditional negate on sign
    logic       sub;       // subtract right input
    logic       trap_en;   // overflow may raise a trap
    logic [1:0] shift;     // left shift of first source
  } op_ctrl_t;

  function automatic op_ctrl_t decode_op(input logic [3:0] code);
    op_ctrl_t c;
    c = '0;
    unique case (code)
      OP_ABS:   begin c.x_zero = 1'b1; c.y_is_a = 1'b1; c.abs_mode = 1'b1; c.trap_en = 1'b1; end
      OP_NEG:   begin c.x_zero = 1'b1; c.y_is_a = 1'b1; c.sub = 1'b1; end
      OP_NEGV:  begin c.x_zero = 1'b1; c.y_is_a = 1'b1; c.sub = 1'b1; c.trap_en = 1'b1; end
      OP_SEXT:  c.sext = 1'b1;
      OP_ADD:   ;
      OP_ADDV:  c.trap_en = 1'b1;
      OP_SUB:   c.sub = 1'b1;
      OP_SUBV:  begin c.sub = 1'b1; c.trap_en = 1'b1; end
      OP_S4ADD: c.shift = 2'd2;
      OP_S8ADD: c.shift = 2'd3;
      OP_S4SUB: begin c.shift = 2'd2; c.sub = 1'b1; end
      OP_S8SUB: begin c.shift = 2'd3; c.sub = 1'b1; end
      default:  c.clear = 1'b1;
    endcase
    return c;
  endfunction

  function automatic logic is_trap_op(input logic [3:0] code);
    return (code == OP_ABS) || (code == OP_NEGV) ||
           (code == OP_ADDV) || (code == OP_SUBV);
  endfunction

endpackage

// File: rtl/arith_operand_prep.sv
module arith_operand_prep #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  src_imm,
  input  logic              use_imm,
  input  logic              quad_sel,
  input  logic              x_zero,
  input  logic              y_is_a,
  input  logic              abs_mode,
  input  logic              sub,
  input  logic [1:0]        shift,
  output logic [DATA_W-1:0] x_op,
  output logic [DATA_W-1:0] y_op,
  output logic              invert
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] b_sel;
  logic [DATA_W-1:0] a_scaled;
  logic [DATA_W-1:0] a_norm;
  logic [DATA_W-1:0] a_scaled_norm;
  logic [DATA_W-1:0] b_norm;

  generate
    if (IMM_W < DATA_W) begin : g_imm_pad
      assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, src_imm};
    end else begin : g_imm_full
      assign imm_ext = src_imm[DATA_W-1:0];
    end
  endgenerate

  function automatic logic [DATA_W-1:0] width_norm(input logic [DATA_W-1:0] v,
                                                   input logic q);
    return q ? v : {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
  endfunction

  always_comb begin
    b_sel         = use_imm ? imm_ext : src_b;
    a_scaled      = src_a << shift;
    a_norm        = width_norm(src_a, quad_sel);
    a_scaled_norm = width_norm(a_scaled, quad_sel);
    b_norm        = width_norm(b_sel, quad_sel);
    x_op          = x_zero ? '0 : a_scaled_norm;
    y_op          = y_is_a ? a_norm : b_norm;
    invert        = sub | (abs_mode & a_norm[DATA_W-1]);
  end

endmodule

// File: rtl/arith_addsub_core.sv
module arith_addsub_core #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] x_op,
  input  logic [DATA_W-1:0] y_op,
  input  logic              invert,
  output logic [DATA_W-1:0] sum,
  output logic              ovf_quad,
  output logic              ovf_long
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0] x_ext;
  logic [DATA_W:0] y_ext;
  logic [DATA_W:0] total;

  always_comb begin
    x_ext    = {x_op[DATA_W-1], x_op};
    y_ext    = {y_op[DATA_W-1], y_op} ^ {(DATA_W+1){invert}};
    total    = x_ext + y_ext + {{DATA_W{1'b0}}, invert};
    sum      = total[DATA_W-1:0];
    // Operands arrive sign-extended to full width, so the exact result
    // fits one bit above the selected width.
    ovf_quad = total[DATA_W] ^ total[DATA_W-1];
    ovf_long = total[HALF_W] ^ total[HALF_W-1];
  end

endmodule

// File: rtl/arith_result_fmt.sv
module arith_result_fmt #(
  parameter int DATA_W = 64
) (
  input  logic                clear,
  input  logic                sext,
  input  logic                trap_en,
  input  logic                quad_sel,
  input  logic [DATA_W/2-1:0] a_low,
  input  logic [DATA_W-1:0]   sum,
  input  logic                ovf_quad,
  input  logic                ovf_long,
  output logic [DATA_W-1:0]   res,
  output logic                trap
);
  localparam int HALF_W = DATA_W / 2;

  always_comb begin
    if (clear) begin
      res  = '0;
      trap = 1'b0;
    end else if (sext) begin
      res  = {{HALF_W{a_low[HALF_W-1]}}, a_low};
      trap = 1'b0;
    end else begin
      res  = quad_sel ? sum : {{HALF_W{sum[HALF_W-1]}}, sum[HALF_W-1:0]};
      trap = trap_en & (quad_sel ? ovf_quad : ovf_long);
    end
  end

endmodule

// File: rtl/int_arith_unit.sv
module int_arith_unit
  import arith_unit_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        op_code,
  input  logic              quad_sel,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [IMM_W-1:0]  src_imm,
  input  logic              use_imm,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              ovf_trap
);
  localparam int HALF_W = DATA_W / 2;

  op_ctrl_t          ctrl;
  logic [DATA_W-1:0] x_op, y_op, sum, res_c;
  logic              invert, ovf_quad, ovf_long, trap_c;

  logic              valid_q, valid_d;
  logic [DATA_W-1:0] res_q, res_d;
  logic              trap_q, trap_d;

  assign ctrl = decode_op(op_code);

  arith_operand_prep #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_prep (
    .src_a    (src_a),
    .src_b    (src_b),
    .src_imm  (src_imm),
    .use_imm  (use_imm),
    .quad_sel (quad_sel),
    .x_zero   (ctrl.x_zero),
    .y_is_a   (ctrl.y_is_a),
    .abs_mode (ctrl.abs_mode),
    .sub      (ctrl.sub),
    .shift    (ctrl.shift),
    .x_op     (x_op),
    .y_op     (y_op),
    .invert   (invert)
  );

  arith_addsub_core #(.DATA_W(DATA_W)) u_core (
    .x_op     (x_op),
    .y_op     (y_op),
    .invert   (invert),
    .sum      (sum),
    .ovf_quad (ovf_quad),
    .ovf_long (ovf_long)
  );

  arith_result_fmt #(.DATA_W(DATA_W)) u_fmt (
    .clear    (ctrl.clear),
    .sext     (ctrl.sext),
    .trap_en  (ctrl.trap_en),
    .quad_sel (quad_sel),
    .a_low    (src_a[HALF_W-1:0]),
    .sum      (sum),
    .ovf_quad (ovf_quad),
    .ovf_long (ovf_long),
    .res      (res_c),
    .trap     (trap_c)
  );

  // Next-state
  always_comb begin
    valid_d = in_valid;
    res_d   = in_valid ? res_c : res_q;
    trap_d  = in_valid & trap_c;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      trap_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      res_q   <= res_d;
      trap_q  <= trap_d;
    end
  end

  assign out_valid = valid_q;
  assign result    = res_q;
  assign ovf_trap  = trap_q;

  // Checks
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_result_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(result));

  assert_trap_with_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> out_valid);

  assert_trap_opcode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_trap |-> is_trap_op($past(op_code)));

  assert_long_sext_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(quad_sel)) |-> (result[DATA_W-1:HALF_W] == {HALF_W{result[HALF_W-1]}}));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code) == OP_CLR) |-> (result == '0 && !ovf_trap));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(op_code) >= OP_S4ADD && $past(op_code) <= OP_S8SUB) |-> !ovf_trap);

endmodule

// File: tb/int_arith_unit_test.sv
`timescale 1ns/1ps
module int_arith_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [3:0]  op_code;
  logic        quad_sel;
  logic [63:0] src_a, src_b;
  logic [7:0]  src_imm;
  logic        use_imm;
  logic        out_valid;
  logic [63:0] result;
  logic        ovf_trap;

  int n_checks = 0;
  int n_fails  = 0;

  localparam logic [63:0] QMIN = 64'h8000_0000_0000_0000;
  localparam logic [63:0] QMAX = 64'h7FFF_FFFF_FFFF_FFFF;

  int_arith_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .quad_sel(quad_sel), .src_a(src_a), .src_b(src_b), .src_imm(src_imm),
    .use_imm(use_imm), .out_valid(out_valid), .result(result), .ovf_trap(ovf_trap)
  );

  always #2 clk = ~clk;

  initial begin
    #(4 * 100000);
    n_fails++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Independent reference built from the requirement text
  function automatic void ref_model(input logic [3:0] op, input logic q,
                                    input logic [63:0] a, input logic [63:0] b,
                                    output logic [63:0] r, output logic t);
    logic signed [127:0] wa, wb, wt;
    logic fits, trapping;
    wa = q ? {{64{a[63]}}, a} : {{96{a[31]}}, a[31:0]};
    wb = q ? {{64{b[63]}}, b} : {{96{b[31]}}, b[31:0]};
    trapping = 1'b0;
    case (op)
      4'd1:  begin wt = (wa < 0) ? -wa : wa; trapping = 1'b1; end
      4'd2:  wt = -wa;
      4'd3:  begin wt = -wa; trapping = 1'b1; end
      4'd4:  wt = {{96{a[31]}}, a[31:0]};
      4'd5:  wt = wa + wb;
      4'd6:  begin wt = wa + wb; trapping = 1'b1; end
      4'd7:  wt = wa - wb;
      4'd8:  begin wt = wa - wb; trapping = 1'b1; end
      4'd9:  wt = 4 * wa + wb;
      4'd10: wt = 8 * wa + wb;
      4'd11: wt = 4 * wa - wb;
      4'd12: wt = 8 * wa - wb;
      default: wt = '0;
    endcase
    if (q) fits = (wt >= -(128'sd1 <<< 63)) && (wt < (128'sd1 <<< 63));
    else   fits = (wt >= -(128'sd1 <<< 31)) && (wt < (128'sd1 <<< 31));
    r = (q || op == 4'd4) ? wt[63:0] : {{32{wt[31]}}, wt[31:0]};
    t = trapping && !fits;
  endfunction

  task automatic run_op(input string req, input logic [3:0] op, input logic q,
                        input logic [63:0] a, input logic [63:0] b,
                        input logic [7:0] imm, input logic ui);
    logic [63:0] exp_r, beff;
    logic exp_t;
    @(negedge clk);
    in_valid = 1'b1; op_code = op; quad_sel = q;
    src_a = a; src_b = b; src_imm = imm; use_imm = ui;
    @(negedge clk);
    in_valid = 1'b0;
    src_b = ~src_b;
    beff = ui ? {56'd0, imm} : b;
    ref_model(op, q, a, beff, exp_r, exp_t);
    check(req, "result", result, exp_r);
    check(req, "ovf_trap", {63'd0, ovf_trap}, {63'd0, exp_t});
    check("R2", "out_valid", {63'd0, out_valid}, 64'd1);
  endtask

  task automatic test_reset;
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; quad_sel = 1'b1;
    src_a = '0; src_b = '0; src_imm = '0; use_imm = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", {63'd0, out_valid}, 64'd0);
    check("R1", "ovf_trap in reset", {63'd0, ovf_trap}, 64'd0);
    check("R1", "result in reset", result, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "out_valid after release", {63'd0, out_valid}, 64'd0);
    check("R1", "result after release", result, 64'd0);
  endtask

  task automatic test_add_sub;
    run_op("R4", 4'd5, 1'b1, 64'd5, 64'd7, 8'd0, 1'b0);
    check("R4", "literal 5+7", result, 64'd12);
    run_op("R4", 4'd7, 1'b1, 64'd100, 64'd250, 8'd0, 1'b0);
    run_op("R4", 4'd5, 1'b1, 64'd100, 64'hDEAD_BEEF, 8'hFF, 1'b1);
    check("R4", "imm zero-extended 100+255", result, 64'd355);
    run_op("R4", 4'd8, 1'b1, 64'd9, 64'hFFFF, 8'h80, 1'b1);
  endtask

  task automatic test_overflow;
    run_op("R10", 4'd6, 1'b1, QMAX, 64'd1, 8'd0, 1'b0);
    check("R10", "addv quad trap", {63'd0, ovf_trap}, 64'd1);
    run_op("R10", 4'd5, 1'b1, QMAX, 64'd1, 8'd0, 1'b0);
    check("R10", "add quad wrap", result, QMIN);
    run_op("R10", 4'd8, 1'b1, QMIN, 64'd1, 8'd0, 1'b0);
    run_op("R10", 4'd7, 1'b1, QMIN, 64'd1, 8'd0, 1'b0);
    run_op("R10", 4'd6, 1'b0, 64'hDEAD_0000_7FFF_FFFF, 64'd1, 8'd0, 1'b0);
    check("R10", "addv long wrap", result, 64'hFFFF_FFFF_8000_0000);
    run_op("R10", 4'd8, 1'b0, 64'h0000_0000_8000_0000, 64'h1234_0000_0000_0001, 8'd0, 1'b0);
    run_op("R10", 4'd6, 1'b0, 64'h0000_0000_7FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, 1'b0);
    check("R10", "addv long no trap at edge", {63'd0, ovf_trap}, 64'd0);
  endtask

  task automatic test_longword;
    run_op("R6", 4'd7, 1'b0, 64'hAAAA_5555_0000_0003, 64'h5555_AAAA_0000_0005, 8'd0, 1'b0);
    check("R6", "long 3-5 sign-extended", result, 64'hFFFF_FFFF_FFFF_FFFE);
    run_op("R6", 4'd5, 1'b0, 64'hFFFF_FFFF_0000_0010, 64'h0, 8'h20, 1'b1);
    check("R6", "long upper ignored", result, 64'd48);
  endtask

  task automatic test_scaled;
    run_op("R5", 4'd9, 1'b1, 64'd3, 64'd1, 8'd0, 1'b0);
    check("R5", "4*3+1", result, 64'd13);
    run_op("R5", 4'd12, 1'b1, 64'd2, 64'd20, 8'd0, 1'b0);
    check("R5", "8*2-20", result, 64'hFFFF_FFFF_FFFF_FFFC);
    run_op("R5", 4'd10, 1'b1, 64'h1000_0000_0000_0000, 64'd1, 8'd0, 1'b0);
    check("R5", "s8add wraps silently", {63'd0, ovf_trap}, 64'd0);
    run_op("R5", 4'd11, 1'b0, 64'h4000_0000, 64'd1, 8'd0, 1'b0);
    run_op("R5", 4'd9, 1'b0, 64'h7FFF_FFFF, 64'h0, 8'd7, 1'b1);
  endtask

  task automatic test_negate;
    run_op("R7", 4'd2, 1'b0, 64'h0000_0000_8000_0000, 64'd0, 8'd0, 1'b0);
    check("R7", "neg long min no trap", {63'd0, ovf_trap}, 64'd0);
    run_op("R7", 4'd3, 1'b0, 64'h0000_0000_8000_0000, 64'd0, 8'd0, 1'b0);
    check("R7", "negv long min trap", {63'd0, ovf_trap}, 64'd1);
    run_op("R7", 4'd3, 1'b1, 64'd5, 64'd0, 8'd0, 1'b0);
    run_op("R7", 4'd3, 1'b1, QMIN, 64'd0, 8'd0, 1'b0);
    run_op("R7", 4'd2, 1'b0, 64'h1111_1111_0000_0001, 64'd0, 8'd0, 1'b0);
  endtask

  task automatic test_abs;
    run_op("R8", 4'd1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF7, 64'd0, 8'd0, 1'b0);
    check("R8", "abs -9", result, 64'd9);
    run_op("R8", 4'd1, 1'b1, 64'd42, 64'd0, 8'd0, 1'b0);
    run_op("R8", 4'd1, 1'b0, 64'h0000_0000_8000_0000, 64'd0, 8'd0, 1'b0);
    check("R8", "abs long min trap", {63'd0, ovf_trap}, 64'd1);
    run_op("R8", 4'd1, 1'b1, QMIN, 64'd0, 8'd0, 1'b0);
    run_op("R8", 4'd1, 1'b0, 64'h0000_0001_FFFF_FFFE, 64'd0, 8'd0, 1'b0);
  endtask

  task automatic test_sext_clear;
    run_op("R9", 4'd4, 1'b1, 64'h1234_5678_8000_0001, 64'd0, 8'd0, 1'b0);
    check("R9", "sext negative", result, 64'hFFFF_FFFF_8000_0001);
    run_op("R9", 4'd4, 1'b0, 64'hFFFF_0000_7000_0000, 64'd0, 8'd0, 1'b0);
    run_op("R3", 4'd0, 1'b1, QMAX, QMAX, 8'd0, 1'b0);
    check("R3", "clear", result, 64'd0);
    run_op("R3", 4'd15, 1'b1, QMIN, 64'd1, 8'd0, 1'b0);
    run_op("R3", 4'd13, 1'b0, 64'd77, 64'd1, 8'd0, 1'b0);
  endtask

  task automatic test_hold_and_pulse;
    logic [63:0] kept;
    run_op("R11", 4'd6, 1'b1, QMAX, QMAX, 8'd0, 1'b0);
    kept = result;
    @(negedge clk);
    check("R2", "out_valid drops", {63'd0, out_valid}, 64'd0);
    check("R11", "trap drops", {63'd0, ovf_trap}, 64'd0);
    check("R2", "result held", result, kept);
    src_a = 64'd1; op_code = 4'd0;
    repeat (2) @(negedge clk);
    check("R2", "result held while idle", result, kept);
    // back to back: trap then clean
    in_valid = 1'b1; op_code = 4'd8; quad_sel = 1'b1; use_imm = 1'b0;
    src_a = QMIN; src_b = 64'd1;
    @(negedge clk);
    op_code = 4'd5; src_a = 64'd2; src_b = 64'd3;
    check("R11", "first of pair traps", {63'd0, ovf_trap}, 64'd1);
    check("R10", "first of pair result", result, QMAX);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", "second of pair no trap", {63'd0, ovf_trap}, 64'd0);
    check("R4", "second of pair result", result, 64'd5);
    check("R2", "valid on second", {63'd0, out_valid}, 64'd1);
  endtask

  initial begin
    test_reset;
    test_add_sub;
    test_overflow;
    test_longword;
    test_scaled;
    test_negate;
    test_abs;
    test_sext_clear;
    test_hold_and_pulse;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule